// File: doc/BRIEF.md
# GPIO Port with Reset-Time Clock-Mask Loader

A four-pin general-purpose I/O port controlled through a small synchronous register port. Software sets a direction bit per pin, an output level per pin, and reads back the synchronized level of every pin. Each pin is modelled as three separate signals: an output value, an output enable and an input level.

Straight after the primary reset is released, and only if the secondary reset is still held at that moment, the block takes the pins over for a fixed number of cycles. During that window it drives an external parallel-in/serial-out shift register. One pin acts as a shift strobe and another as an active-low load/shift select. The block captures a 16-bit clock-disable mask from a dedicated serial input, one bit per strobe. When the window closes the mask sits in a clock-mask register that software may read and overwrite, and the pins return to register control.

Top module: `gpio_mask_port`

## Requirements
- R1: While the primary reset (`prst_n`, active low) is held, every pin enable is 0, every pin output is 0, and every register reads 0.
- R2: Outside the load window, `pad_oe` equals the direction register (address 0, bits 3:0) and `pad_out` equals the output-data register (address 1, bits 3:0). Both read back what was written, with the upper read bits 0.
- R3: Address 2 returns in bits 3:0 the level of all four `pad_in` pins as sampled two rising clock edges earlier, whatever their direction. Writes to address 2 change no register.
- R4: The window opens at the first clock edge after `prst_n` releases, but only if `srst_n` is low at that edge. It lasts 23 cycles when `fast_mode` is 0 and 46 cycles when it is 1. `fast_mode` is sampled at that edge and held for the whole window. If `srst_n` is high at that edge, no window occurs.
- R5: During the window `pad_oe` is 4'b0101 and `pad_out[1]` and `pad_out[3]` are 0, whatever the registers hold. Register writes made during the window still land and reach the pins once it closes.
- R6: `pad_out[2]` is the load/shift select: 0 during load step 0 and 1 for every later step. A step is one cycle in normal mode and two cycles in fast mode.
- R7: `pad_out[0]` is the shift strobe, high exactly in the capture cycles. These are cycles 1 to 16 of the window in normal mode, and the odd cycles 3 to 33 in fast mode. `mask_sin` is sampled at the clock edge that ends each capture cycle.
- R8: The clock-mask register (address 3, 16 bits) reads 0 and ignores writes until the window has closed or has been skipped. At the end of the window it takes the captured mask, with the first captured bit in bit 15.
- R9: Once the window has closed or been skipped, address 3 reads back any 16-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| prst_n | input | 1 | Primary reset, active low, asynchronous assert |
| srst_n | input | 1 | Secondary reset level, active low, selects whether the window runs |
| fast_mode | input | 1 | Selects the doubled window and two-cycle steps |
| reg_addr | input | 2 | Register address: 0 direction, 1 output data, 2 input data, 3 clock mask |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on the address |
| pad_in | input | 4 | Pin input levels |
| pad_out | output | 4 | Pin output values |
| pad_oe | output | 4 | Pin output enables |
| mask_sin | input | 1 | Serial mask data from the external shift register |

## Verification
The bench builds the block with its default parameters: four pins, a 16-bit mask, and windows of 23 and 46 cycles. With these values both window lengths and a complete mask capture run end to end in a few hundred cycles. This lets every cycle of both windows be compared against the expected strobe and select values, including the last hardware-owned cycle and the first cycle handed back to software. A register write attempted mid-window, a skipped window, a mode change during the window and randomly drawn pin and register patterns are all reachable within the same short run.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

  typedef enum logic [1:0] {
    RA_DIR  = 2'd0,
    RA_DOUT = 2'd1,
    RA_DIN  = 2'd2,
    RA_CKM  = 2'd3
  } reg_addr_e;

  // Window length in cycles for the selected mode.
  function automatic int win_len(input logic fast, input int n_norm, input int n_fast);
    return fast ? n_fast : n_norm;
  endfunction

  // Load step reached by a window cycle.
  function automatic int step_of(input int cyc, input logic fast);
    return fast ? (cyc / 2) : cyc;
  endfunction

  // A capture cycle: steps 1..nbits, and in fast mode only the second
  // cycle of each step.
  function automatic logic is_capture(input int cyc, input logic fast, input int nbits);
    int s;
    s = step_of(cyc, fast);
    if (fast && (cyc % 2 == 0)) return 1'b0;
    return (s >= 1) && (s <= nbits);
  endfunction

endpackage

// File: rtl/gpm_win_ctrl.sv
module gpm_win_ctrl
  import gpm_pkg::*;
#(
  parameter int MASK_W   = 16,
  parameter int WIN_NORM = 23,
  parameter int WIN_FAST = 46
) (
  input  logic              clk,
  input  logic              prst_n,
  input  logic              srst_n,
  input  logic              fast_mode,
  input  logic              mask_sin,
  output logic              win_act,
  output logic              win_done,
  output logic              win_end,
  output logic              cap_evt,
  output logic              load_n,
  output logic [MASK_W-1:0] mask_cap
);

  localparam int CW = $clog2(WIN_FAST + 1);
  localparam int SW = $clog2(MASK_W + 2);

  logic              first_q;
  logic              act_q;
  logic              done_q;
  logic              fast_q;
  logic [CW-1:0]     cnt_q;
  logic [MASK_W-1:0] shreg_q;
  int                cyc_i;

  assign cyc_i   = int'(cnt_q);
  assign win_end = act_q && (cyc_i == win_len(fast_q, WIN_NORM, WIN_FAST) - 1);
  assign cap_evt = act_q && is_capture(cyc_i, fast_q, MASK_W);
  assign load_n  = (step_of(cyc_i, fast_q) != 0);

  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n) begin
      first_q <= 1'b1;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      fast_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (first_q) begin
      first_q <= 1'b0;
      fast_q  <= fast_mode;
      cnt_q   <= '0;
      if (!srst_n) act_q  <= 1'b1;
      else         done_q <= 1'b1;
    end else if (act_q) begin
      if (win_end) begin
        act_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n)      shreg_q <= '0;
    else if (cap_evt) shreg_q <= {shreg_q[MASK_W-2:0], mask_sin};
  end

  assign win_act  = act_q;
  assign win_done = done_q;
  assign mask_cap = shreg_q;

  // Checker state: strobes seen in this window.
  logic [SW-1:0] cap_seen_q;
  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n)      cap_seen_q <= '0;
    else if (cap_evt) cap_seen_q <= cap_seen_q + 1'b1;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!prst_n)
    act_q |-> (cyc_i < win_len(fast_q, WIN_NORM, WIN_FAST)));

  p_start_cond_r4: assert property (@(posedge clk) disable iff (!prst_n)
    $rose(act_q) |-> !$past(srst_n));

  p_fast_held_r4: assert property (@(posedge clk) disable iff (!prst_n)
    (act_q && $past(act_q)) |-> $stable(fast_q));

  p_cap_count_r7: assert property (@(posedge clk) disable iff (!prst_n)
    $fell(act_q) |-> (int'(cap_seen_q) == MASK_W));

  p_no_reopen_r4: assert property (@(posedge clk) disable iff (!prst_n)
    done_q |=> !act_q);

endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
  import gpm_pkg::*;
#(
  parameter int NPIN = 4,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            prst_n,
  input  logic [1:0]      reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NPIN-1:0] pad_in,
  input  logic            win_done,
  input  logic            win_end,
  input  logic [DW-1:0]   mask_cap,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] dout_q
);

  logic [NPIN-1:0] sync1_q;
  logic [NPIN-1:0] din_q;
  logic [DW-1:0]   ckm_q;
  reg_addr_e       ra;

  assign ra = reg_addr_e'(reg_addr);

  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n) begin
      sync1_q <= '0;
      din_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      din_q   <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else if (reg_we) begin
      if (ra == RA_DIR)  dir_q  <= reg_wdata[NPIN-1:0];
      if (ra == RA_DOUT) dout_q <= reg_wdata[NPIN-1:0];
    end
  end

  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n)                                 ckm_q <= '0;
    else if (win_end)                            ckm_q <= mask_cap;
    else if (reg_we && ra == RA_CKM && win_done) ckm_q <= reg_wdata;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (ra)
      RA_DIR:  reg_rdata[NPIN-1:0] = dir_q;
      RA_DOUT: reg_rdata[NPIN-1:0] = dout_q;
      RA_DIN:  reg_rdata[NPIN-1:0] = din_q;
      RA_CKM:  reg_rdata           = ckm_q;
      default: reg_rdata           = '0;
    endcase
  end

  // Checker state: edges since reset, saturating at 2.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 1'b1;
  end

  p_sync_lat_r3: assert property (@(posedge clk) disable iff (!prst_n)
    (age_q == 2'd2) |-> (din_q == $past(pad_in, 2)));

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!prst_n)
    !win_done |-> (ckm_q == '0));

  p_mask_wr_r9: assert property (@(posedge clk) disable iff (!prst_n)
    (win_done && reg_we && ra == RA_CKM) |=> (ckm_q == $past(reg_wdata)));

endmodule

// File: rtl/gpm_pad_mux.sv
module gpm_pad_mux #(
  parameter int NPIN     = 4,
  parameter int CLK_PIN  = 0,
  parameter int LOAD_PIN = 2
) (
  input  logic            clk,
  input  logic            prst_n,
  input  logic            win_act,
  input  logic            cap_evt,
  input  logic            load_n,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] dout_q,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);

  localparam logic [NPIN-1:0] HW_PINS = (NPIN'(1) << CLK_PIN) | (NPIN'(1) << LOAD_PIN);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic hw_o;
    logic hw_e;
    if (i == CLK_PIN) begin : g_clk
      assign hw_o = cap_evt;
      assign hw_e = 1'b1;
    end else if (i == LOAD_PIN) begin : g_load
      assign hw_o = load_n;
      assign hw_e = 1'b1;
    end else begin : g_idle
      assign hw_o = 1'b0;
      assign hw_e = 1'b0;
    end
    assign pad_out[i] = win_act ? hw_o : dout_q[i];
    assign pad_oe[i]  = win_act ? hw_e : dir_q[i];
  end

  p_sw_blocked_r5: assert property (@(posedge clk) disable iff (!prst_n)
    win_act |-> (((pad_oe | pad_out) & ~HW_PINS) == '0));

  p_hw_enabled_r5: assert property (@(posedge clk) disable iff (!prst_n)
    win_act |-> (pad_oe == HW_PINS));

  p_sw_pass_r2: assert property (@(posedge clk) disable iff (!prst_n)
    (!win_act && $past(!win_act)) |-> (pad_oe == dir_q && pad_out == dout_q));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpm_pkg::*;
#(
  parameter int NPIN     = 4,
  parameter int MASK_W   = 16,
  parameter int WIN_NORM = 23,
  parameter int WIN_FAST = 46,
  parameter int CLK_PIN  = 0,
  parameter int LOAD_PIN = 2
) (
  input  logic              clk,
  input  logic              prst_n,
  input  logic              srst_n,
  input  logic              fast_mode,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [MASK_W-1:0] reg_wdata,
  output logic [MASK_W-1:0] reg_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  input  logic              mask_sin
);

  logic              win_act;
  logic              win_done;
  logic              win_end;
  logic              cap_evt;
  logic              load_n;
  logic [MASK_W-1:0] mask_cap;
  logic [NPIN-1:0]   dir_q;
  logic [NPIN-1:0]   dout_q;

  gpm_win_ctrl #(
    .MASK_W(MASK_W), .WIN_NORM(WIN_NORM), .WIN_FAST(WIN_FAST)
  ) u_win (
    .clk(clk), .prst_n(prst_n), .srst_n(srst_n), .fast_mode(fast_mode),
    .mask_sin(mask_sin), .win_act(win_act), .win_done(win_done),
    .win_end(win_end), .cap_evt(cap_evt), .load_n(load_n), .mask_cap(mask_cap)
  );

  gpm_regs #(.NPIN(NPIN), .DW(MASK_W)) u_regs (
    .clk(clk), .prst_n(prst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .win_done(win_done), .win_end(win_end), .mask_cap(mask_cap),
    .dir_q(dir_q), .dout_q(dout_q)
  );

  gpm_pad_mux #(.NPIN(NPIN), .CLK_PIN(CLK_PIN), .LOAD_PIN(LOAD_PIN)) u_pads (
    .clk(clk), .prst_n(prst_n), .win_act(win_act), .cap_evt(cap_evt),
    .load_n(load_n), .dir_q(dir_q), .dout_q(dout_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  p_rst_quiet_r1: assert property (@(posedge clk)
    !prst_n |-> (pad_oe == '0 && pad_out == '0 && reg_rdata == '0));

endmodule

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/1ps
module tb_gpio_mask_port;

  logic        clk = 1'b0;
  logic        prst_n, srst_n, fast_mode, reg_we, mask_sin;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [3:0]  pad_in, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_dir, exp_dout;

  always #4 clk = ~clk;

  gpio_mask_port dut (
    .clk(clk), .prst_n(prst_n), .srst_n(srst_n), .fast_mode(fast_mode),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .mask_sin(mask_sin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_strobe(input int c, input bit f);
    if (f) return (c >= 3) && (c <= 33) && (c % 2 == 1);
    return (c >= 1) && (c <= 16);
  endfunction

  function automatic bit exp_load(input int c, input bit f);
    return f ? (c >= 2) : (c >= 1);
  endfunction

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_window(input bit f, input logic [15:0] m, input bit wr_mid);
    int len;
    int k;
    logic [15:0] v;
    len = f ? 46 : 23;
    k = 0;
    @(negedge clk);
    prst_n = 1'b0; srst_n = 1'b0; fast_mode = f; reg_we = 1'b0; mask_sin = 1'b0;
    exp_dir = '0; exp_dout = '0;
    @(negedge clk);
    prst_n = 1'b1;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      chk("R5 oe in window", pad_oe, 4'b0101);
      chk("R5 idle pins", {pad_out[3], pad_out[1]}, 2'b00);
      chk("R6 load select", pad_out[2], exp_load(c, f));
      chk("R7 shift strobe", pad_out[0], exp_strobe(c, f));
      if (exp_strobe(c, f)) begin
        mask_sin = m[15-k];
        k++;
      end else begin
        mask_sin = 1'($urandom);
      end
      if (c == 10) fast_mode = ~f;
      if (wr_mid) begin
        if (c == 5) begin reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h000F; exp_dir = 4'hF; end
        if (c == 6) begin reg_addr = 2'd1; reg_wdata = 16'h000A; exp_dout = 4'hA; end
        if (c == 7) begin reg_addr = 2'd3; reg_wdata = 16'hFFFF; end
        if (c == 8) begin
          reg_we = 1'b0;
          rd(2'd3, v);
          chk("R8 mask write ignored in window", v, 16'h0000);
        end
      end
    end
    @(negedge clk);
    chk("R4 window end oe", pad_oe, exp_dir);
    chk("R4 window end out", pad_out, exp_dout);
    chk("R7 bits captured", k, 16);
    rd(2'd3, v);
    chk("R8 captured mask", v, m);
    srst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] v;
    logic [3:0]  hist [0:1];
    void'($urandom(32'd1234));
    prst_n = 1'b0; srst_n = 1'b0; fast_mode = 1'b0; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0; pad_in = 4'h9; mask_sin = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 oe", pad_oe, 4'h0);
    chk("R1 out", pad_out, 4'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg read", v, 16'h0000);
    end

    // Normal-mode window with writes attempted mid-window
    run_window(1'b0, 16'hB5C3, 1'b1);

    // R2 random register patterns
    for (int i = 0; i < 20; i++) begin
      logic [3:0] d, o;
      d = 4'($urandom); o = 4'($urandom);
      wr(2'd0, {12'hFFF, d});
      wr(2'd1, {12'hABC, o});
      chk("R2 pad_oe", pad_oe, d);
      chk("R2 pad_out", pad_out, o);
      rd(2'd0, v); chk("R2 dir readback", v, {12'h0, d});
      rd(2'd1, v); chk("R2 dout readback", v, {12'h0, o});
    end

    // R3 input synchronizer latency, all pins regardless of direction
    wr(2'd0, 16'h0005);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      pad_in = 4'($urandom);
      if (i >= 2) begin
        rd(2'd2, v);
        chk("R3 input data latency", v, {12'h0, hist[0]});
      end
      hist[0] = hist[1];
      hist[1] = pad_in;
    end
    wr(2'd2, 16'hFFFF);
    rd(2'd0, v); chk("R3 din write leaves dir", v, 16'h0005);
    rd(2'd1, v); chk("R3 din write leaves dout", v, {12'h0, pad_out});
    chk("R3 din write leaves pins", pad_oe, 4'h5);

    // R9 mask writable after window
    v = 16'($urandom);
    wr(2'd3, v);
    begin
      logic [15:0] r;
      rd(2'd3, r);
      chk("R9 mask readback", r, v);
    end

    // Fast-mode window, mode input flipped mid-window
    run_window(1'b1, 16'h6E19, 1'b0);
    run_window(1'b1, 16'($urandom), 1'b0);

    // R4 skipped window when secondary reset is high at release
    @(negedge clk);
    prst_n = 1'b0; srst_n = 1'b1;
    @(negedge clk);
    prst_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R4 no window pins", pad_oe, 4'h0);
    end
    rd(2'd3, v);
    chk("R4 no window mask", v, 16'h0000);
    wr(2'd3, 16'h1234);
    rd(2'd3, v);
    chk("R9 mask write after skip", v, 16'h1234);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule